// File: doc/BRIEF.md
# Eight-Bit Accumulator ALU with Carry Rotates

This block is the arithmetic and logic unit of a small accumulator-style microcontroller. It takes two operands, a carry input and a four-bit operation code. From these it computes one result, a candidate carry and a candidate zero flag. The surrounding core chooses the operands and decides which flags and registers to update. This block only forms the values for the operation that is currently selected.

Besides add, subtract and the bitwise operations, the unit has two rotates that pass through the carry bit and a nibble swap. These let shift chains and packed-decimal handling run in a single instruction.

The block is purely combinational. It has no clock, no reset and no storage. The operand width is a parameter with a default of 8, and it must be even so that the swap can split the word into two equal halves.

Top module: `alu8_core`

## Requirements
- R1: Operation code 4'h0 (add) gives res = (A + B) mod 256, and the carry is bit 8 of the 9-bit sum. The carry input is ignored.
- R2: Operation code 4'h1 (subtract) gives res = (A − B) mod 256. The carry is 1 exactly when A ≥ B as unsigned numbers. The carry input is ignored.
- R3: Codes 4'h2, 4'h3 and 4'h4 give A AND B, A OR B and A XOR B respectively.
- R4: Code 4'h5 (complement) gives the bitwise inverse of A. Operand B has no effect on it.
- R5: Code 4'h6 (rotate right through carry) gives {cin, A[7:1]}, with the carry equal to A[0].
- R6: Code 4'h7 (rotate left through carry) gives {A[6:0], cin}, with the carry equal to A[7].
- R7: Code 4'h8 (nibble swap) gives {A[3:0], A[7:4]}.
- R8: For codes 4'h2 to 4'h5 and 4'h8, the carry output equals the carry input.
- R9: The zero output is 1 exactly when the 8-bit result is 8'h00, for every code.
- R10: Codes 4'h9 to 4'hF give a result of 8'h00 and pass the carry input through. The zero output is therefore 1.
- R11: The outputs depend only on the present inputs. All-zero inputs give res 8'h00, carry 0 and zero 1, and the outputs stay constant while the inputs are held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 8 | Operand A (accumulator side) |
| opb_i | input | 8 | Operand B |
| cin_i | input | 1 | Carry input |
| op_i | input | 4 | Operation code |
| res_o | output | 8 | Result |
| cout_o | output | 1 | Candidate carry |
| zero_o | output | 1 | Candidate zero flag |

## Verification
Every output is due in the same cycle as its stimulus, because no register lies between any input and any output. The bench drives new inputs just after a rising edge of its pacing clock. It samples the outputs at the following falling edge, half a period later, when the logic has settled. A held-input test samples across several falling edges to confirm that nothing changes without an input change.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'h0,
    OP_SUB  = 4'h1,
    OP_AND  = 4'h2,
    OP_OR   = 4'h3,
    OP_XOR  = 4'h4,
    OP_COM  = 4'h5,
    OP_ROR  = 4'h6,
    OP_ROL  = 4'h7,
    OP_SWAP = 4'h8
  } alu_op_e;
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] res_o,
  output logic         cout_o
);
  // Subtract is formed as A + ~B + 1, so bit W is the inverted borrow.
  function automatic logic [W:0] addsub(input logic [W-1:0] x,
                                        input logic [W-1:0] y,
                                        input logic         s);
    logic [W:0] ext_y;
    ext_y = s ? {1'b0, ~y} : {1'b0, y};
    return {1'b0, x} + ext_y + {{W{1'b0}}, s};
  endfunction

  logic [W:0] sum_w;
  assign sum_w  = addsub(a_i, b_i, sub_i);
  assign res_o  = sum_w[W-1:0];
  assign cout_o = sum_w[W];

  always_comb begin
    if (!$isunknown({a_i, b_i, sub_i})) begin
      if (sub_i) begin
        AST_SUB_NOBORROW: assert (cout_o == (a_i >= b_i)); // R2
      end else begin
        AST_ADD_WRAP: assert (cout_o == (res_o < a_i)); // R1
      end
    end
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   sel_i,
  output logic [W-1:0] res_o
);
  logic [W-1:0] and_w, or_w, xor_w, com_w;
  assign and_w = a_i & b_i;
  assign or_w  = a_i | b_i;
  assign xor_w = a_i ^ b_i;
  assign com_w = ~a_i;

  always_comb begin
    unique case (sel_i)
      2'd0:    res_o = and_w;
      2'd1:    res_o = or_w;
      2'd2:    res_o = xor_w;
      default: res_o = com_w;
    endcase
  end

  always_comb begin
    if (!$isunknown({a_i, b_i})) begin
      AST_XOR_FROM_ANDOR: assert (xor_w == (or_w & ~and_w)); // R3
      AST_COM_NO_OVERLAP: assert ((com_w & a_i) == '0 && (com_w | a_i) == '1); // R4
    end
  end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic         cin_i,
  input  logic [1:0]   sel_i,
  output logic [W-1:0] res_o,
  output logic         cout_o
);
  localparam int H = W / 2;

  // Rotates return {carry_out, result}.
  function automatic logic [W:0] rot_r(input logic [W-1:0] x, input logic c);
    return {x[0], c, x[W-1:1]};
  endfunction

  function automatic logic [W:0] rot_l(input logic [W-1:0] x, input logic c);
    return {x[W-1], x[W-2:0], c};
  endfunction

  function automatic logic [W-1:0] swap_halves(input logic [W-1:0] x);
    return {x[H-1:0], x[W-1:H]};
  endfunction

  logic [W:0]   ror_w, rol_w, back_r_w, back_l_w;
  logic [W-1:0] swp_w;

  assign ror_w = rot_r(a_i, cin_i);
  assign rol_w = rot_l(a_i, cin_i);
  assign swp_w = swap_halves(a_i);
  // Round trips, used only by the checks below.
  assign back_r_w = rot_l(ror_w[W-1:0], ror_w[W]);
  assign back_l_w = rot_r(rol_w[W-1:0], rol_w[W]);

  always_comb begin
    unique case (sel_i)
      2'd0:    begin res_o = ror_w[W-1:0]; cout_o = ror_w[W]; end
      2'd1:    begin res_o = rol_w[W-1:0]; cout_o = rol_w[W]; end
      default: begin res_o = swp_w;        cout_o = cin_i;    end
    endcase
  end

  always_comb begin
    if (!$isunknown({a_i, cin_i})) begin
      AST_ROR_ROUNDTRIP: assert (back_r_w == {cin_i, a_i}); // R5
      AST_ROL_ROUNDTRIP: assert (back_l_w == {cin_i, a_i}); // R6
      AST_SWAP_INVOLUTION: assert (swap_halves(swp_w) == a_i); // R7
    end
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core #(
  parameter int W = 8
) (
  input  logic [W-1:0]               opa_i,
  input  logic [W-1:0]               opb_i,
  input  logic                       cin_i,
  input  logic [alu8_pkg::OP_W-1:0]  op_i,
  output logic [W-1:0]               res_o,
  output logic                       cout_o,
  output logic                       zero_o
);
  import alu8_pkg::*;

  generate
    if ((W % 2) != 0 || W < 2) begin : g_bad_width
      $error("alu8_core: W must be even and at least 2");
    end
  endgenerate

  logic [W-1:0] ar_res, lg_res, sh_res;
  logic         ar_c, sh_c;
  logic [1:0]   lg_sel, sh_sel;
  logic         is_arith, is_logic, is_shift;

  assign is_arith = (op_i == OP_ADD) || (op_i == OP_SUB);
  assign is_logic = (op_i >= OP_AND) && (op_i <= OP_COM);
  assign is_shift = (op_i >= OP_ROR) && (op_i <= OP_SWAP);
  assign lg_sel   = 2'(op_i - OP_AND);
  assign sh_sel   = 2'(op_i - OP_ROR);

  alu8_arith #(.W(W)) u_arith (
    .a_i(opa_i), .b_i(opb_i), .sub_i(op_i == OP_SUB),
    .res_o(ar_res), .cout_o(ar_c)
  );

  alu8_logic #(.W(W)) u_logic (
    .a_i(opa_i), .b_i(opb_i), .sel_i(lg_sel), .res_o(lg_res)
  );

  alu8_shift #(.W(W)) u_shift (
    .a_i(opa_i), .cin_i(cin_i), .sel_i(sh_sel),
    .res_o(sh_res), .cout_o(sh_c)
  );

  always_comb begin
    if (is_arith) begin
      res_o = ar_res; cout_o = ar_c;
    end else if (is_logic) begin
      res_o = lg_res; cout_o = cin_i;
    end else if (is_shift) begin
      res_o = sh_res; cout_o = sh_c;
    end else begin
      res_o = '0;     cout_o = cin_i;
    end
  end

  assign zero_o = ~|res_o;

  always_comb begin
    if (!$isunknown({opa_i, opb_i, cin_i, op_i})) begin
      AST_ZERO_FLAG: assert (zero_o == ($countones(res_o) == 0)); // R9
      AST_ONE_UNIT: assert ($onehot0({is_arith, is_logic, is_shift})); // R10
      if (is_logic || op_i == OP_SWAP) begin
        AST_CARRY_PASS: assert (cout_o == cin_i); // R8
      end
      if (!is_arith && !is_logic && !is_shift) begin
        AST_UNUSED_CODE: assert (zero_o && cout_o == cin_i); // R10
      end
    end
  end
endmodule

// File: tb/alu8_core_test.sv
module alu8_core_test;
  logic       clk = 1'b0;
  logic [7:0] a, b;
  logic       ci;
  logic [3:0] op;
  logic [7:0] res;
  logic       co, zf;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk; // 125 MHz

  alu8_core uut (
    .opa_i(a), .opb_i(b), .cin_i(ci), .op_i(op),
    .res_o(res), .cout_o(co), .zero_o(zf)
  );

  // {op, a, b, cin, res, cout, zero}
  localparam int NV = 17;
  localparam logic [30:0] VEC [NV] = '{
    {4'h0, 8'h0F, 8'h01, 1'b0, 8'h10, 1'b0, 1'b0},
    {4'h0, 8'hFF, 8'h01, 1'b0, 8'h00, 1'b1, 1'b1},
    {4'h0, 8'h80, 8'h80, 1'b0, 8'h00, 1'b1, 1'b1},
    {4'h0, 8'h01, 8'h01, 1'b1, 8'h02, 1'b0, 1'b0},
    {4'h1, 8'h05, 8'h03, 1'b0, 8'h02, 1'b1, 1'b0},
    {4'h1, 8'h03, 8'h05, 1'b1, 8'hFE, 1'b0, 1'b0},
    {4'h1, 8'h42, 8'h42, 1'b0, 8'h00, 1'b1, 1'b1},
    {4'h2, 8'hF0, 8'h3C, 1'b1, 8'h30, 1'b1, 1'b0},
    {4'h3, 8'hA0, 8'h05, 1'b0, 8'hA5, 1'b0, 1'b0},
    {4'h4, 8'h55, 8'h55, 1'b1, 8'h00, 1'b1, 1'b1},
    {4'h5, 8'h0F, 8'hAA, 1'b0, 8'hF0, 1'b0, 1'b0},
    {4'h6, 8'h81, 8'h00, 1'b0, 8'h40, 1'b1, 1'b0},
    {4'h6, 8'h01, 8'h00, 1'b0, 8'h00, 1'b1, 1'b1},
    {4'h7, 8'h81, 8'h00, 1'b1, 8'h03, 1'b1, 1'b0},
    {4'h7, 8'h40, 8'h00, 1'b0, 8'h80, 1'b0, 1'b0},
    {4'h8, 8'h5A, 8'h00, 1'b1, 8'hA5, 1'b1, 1'b0},
    {4'hC, 8'hFF, 8'hFF, 1'b1, 8'h00, 1'b1, 1'b1}
  };

  function automatic string tag(input logic [3:0] o);
    case (o)
      4'h0: return "R1";
      4'h1: return "R2";
      4'h2, 4'h3, 4'h4: return "R3";
      4'h5: return "R4";
      4'h6: return "R5";
      4'h7: return "R6";
      4'h8: return "R7";
      default: return "R10";
    endcase
  endfunction

  // Reference model written from the requirements, returns {res, cout}.
  function automatic logic [8:0] model(input logic [3:0] o, input logic [7:0] x,
                                       input logic [7:0] y, input logic c);
    int s;
    case (o)
      4'h0: begin s = int'(x) + int'(y); return {s[7:0], s[8]}; end
      4'h1: begin s = int'(x) - int'(y); return {s[7:0], (x >= y)}; end
      4'h2: return {x & y, c};
      4'h3: return {x | y, c};
      4'h4: return {x ^ y, c};
      4'h5: return {~x, c};
      4'h6: return {c, x[7:1], x[0]};
      4'h7: return {x[6:0], c, x[7]};
      4'h8: return {x[3:0], x[7:4], c};
      default: return {8'h00, c};
    endcase
  endfunction

  task automatic apply(input logic [3:0] o, input logic [7:0] x,
                       input logic [7:0] y, input logic c);
    @(posedge clk);
    op = o; a = x; b = y; ci = c;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] er,
                       input logic ec, input logic ez);
    n_chk++;
    if (res !== er || co !== ec || zf !== ez) begin
      n_bad++;
      $display("FAIL %s op=%h a=%h b=%h cin=%b: got res=%h c=%b z=%b, expected res=%h c=%b z=%b",
               req, op, a, b, ci, res, co, zf, er, ec, ez);
    end
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [8:0] m;
    op = '0; a = '0; b = '0; ci = 1'b0;

    // R11: all-zero inputs, held for several cycles
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R11", 8'h00, 1'b0, 1'b1);
    end

    // Vector table
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][30:27], VEC[i][26:19], VEC[i][18:11], VEC[i][10]);
      check(tag(VEC[i][30:27]), VEC[i][9:2], VEC[i][1], VEC[i][0]);
    end

    // R4: B has no effect on complement
    apply(4'h5, 8'h3C, 8'h00, 1'b1);
    check("R4", 8'hC3, 1'b1, 1'b0);
    apply(4'h5, 8'h3C, 8'hFF, 1'b1);
    check("R4", 8'hC3, 1'b1, 1'b0);

    // R8: carry passthrough for both carry values
    for (int o = 2; o <= 8; o++) begin
      if (o == 6 || o == 7) continue;
      for (int c = 0; c < 2; c++) begin
        apply(4'(o), 8'h96, 8'h69, 1'(c));
        m = model(4'(o), 8'h96, 8'h69, 1'(c));
        check("R8", m[8:1], 1'(c), m[8:1] == 8'h00);
      end
    end

    // R10: every unused code
    for (int o = 9; o < 16; o++) begin
      apply(4'(o), 8'h7E, 8'h11, 1'b0);
      check("R10", 8'h00, 1'b0, 1'b1);
    end

    // R9: zero flag on a complement that gives zero
    apply(4'h5, 8'hFF, 8'h12, 1'b0);
    check("R9", 8'h00, 1'b0, 1'b1);

    // Random sweep against the reference model
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] ro;
      logic [7:0] ra, rb;
      logic       rc;
      ro = 4'($urandom_range(0, 15));
      ra = 8'($urandom);
      rb = 8'($urandom);
      rc = 1'(i & 1);
      apply(ro, ra, rb, rc);
      m = model(ro, ra, rb, rc);
      check(tag(ro), m[8:1], m[0], m[8:1] == 8'h00);
    end

    // R11: held inputs give stable outputs
    apply(4'h1, 8'h10, 8'h20, 1'b0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R11", 8'hF0, 1'b0, 1'b0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule